// File: doc/BRIEF.md
# Instruction-Gated Logic Self-Test Engine

This block runs a built-in self-test on a small combinational circuit under test: a two-input multiplexer with data inputs A and B and a select S. When the decoded self-test instruction is active, a 4-bit maximal-length pattern generator drives the multiplexer, and a 4-bit serial-input signature register compacts its output. The count, the pattern and the signature move forward only on clocks where the test access port state machine reports the Run-Test/Idle state. In every other state they hold.

After a parameterised number of active clocks, the engine latches a 5-bit result into a data register. The result is the final signature plus a pass bit that is set when the signature matches a golden value. The register is then shifted out serially through the test data pins. When the instruction is inactive, the multiplexer serves its functional pins, and the same 5-bit register acts as a plain serial data register. A fault-injection input can force the multiplexer output to a constant, so that a failing signature can be produced on purpose.

Top module: `lbist_engine`

## Requirements
- R1: After reset, `st_done` is 0, the result register holds all zeros (so `tdo` is 0), the generator holds 4'b0001 and the signature holds 4'b0000.
- R2: While `run_selftest` is 0 and no fault is injected, `func_y` equals `func_a` when `func_s` is 0, and equals `func_b` when `func_s` is 1.
- R3: While `run_selftest` is 1, the multiplexer takes A from generator bit 0, B from bit 1 and S from bit 2. The generator steps as {g[2:0], g[3]^g[2]}, that is, x^4+x^3+1 shifting toward the MSB.
- R4: The count, generator and signature advance only on clocks where `run_selftest` and `in_idle` are both 1 and the test is not done. On any other clock they are unchanged.
- R5: On the clock that completes the TEST_LEN-th active cycle (default 15), `st_done` becomes 1 and the result register loads {pass, signature[3:0]}, where the signature includes that final cycle.
- R6: On each active cycle, the signature steps as {s[2:0], s[3]^s[2]^y}, where y is the multiplexer output. The fault-free default run yields signature 4'b0011.
- R7: The pass bit (result bit 4) is 1 exactly when the final signature equals the GOLDEN parameter (default 4'b0011). With a stuck-at fault injected, the default run gives pass 0.
- R8: On each clock with `shift_dr` high, the result register shifts one place toward `tdo`, taking `tdi` into bit 4. `tdo` always shows bit 0, so the result leaves LSB first. The same shifting works as a plain data register when `run_selftest` is 0.
- R9: A rising edge of `run_selftest` reseeds the generator to 4'b0001, clears the signature, the count and `st_done`. This takes priority over an advance requested on the same clock.
- R10: Once `st_done` is 1, further Run-Test/Idle clocks leave the result register unchanged.
- R11: While `fault_en` is 1, `func_y` equals `fault_val`, in both functional and self-test mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| run_selftest | input | 1 | Decoded self-test instruction active |
| in_idle | input | 1 | TAP state machine is in Run-Test/Idle |
| shift_dr | input | 1 | TAP state machine is in Shift-DR |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out (result bit 0) |
| func_a | input | 1 | Functional data input A |
| func_b | input | 1 | Functional data input B |
| func_s | input | 1 | Functional select input |
| func_y | output | 1 | Multiplexer output |
| fault_en | input | 1 | Force multiplexer output to a constant |
| fault_val | input | 1 | Value forced while fault_en is high |
| st_done | output | 1 | Self-test count has completed |

## Verification
Two events can arrive on the same clock: a rising edge of the self-test instruction and a Run-Test/Idle clock that would otherwise advance the engine. The bench provokes this by raising the instruction with `in_idle` already high. It then judges the result from the multiplexer output on the following cycle, which must reflect the seed pattern rather than the next one, and from a final signature that matches a model run of exactly TEST_LEN steps. Runs with randomly placed non-idle gaps, and a run aborted and restarted part way through, must give the same shifted result as a run without gaps.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
   // source selection for the circuit under test
   typedef enum logic {
      SRC_FUNC = 1'b0,
      SRC_TEST = 1'b1
   } cut_src_e;

   localparam int unsigned LFSR_W_DEF   = 4;
   localparam logic [3:0]  TAPS_X4X3    = 4'b1100;
   localparam logic [3:0]  GEN_SEED_DEF = 4'b0001;
endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
   parameter int unsigned W    = 4,
   parameter logic [W-1:0] TAPS = 4'b1100,
   parameter logic [W-1:0] SEED = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed_load,
   input  logic         step,
   input  logic         ser_in,
   output logic [W-1:0] q,
   output logic [W-1:0] q_next
);
   if (W < 2) begin : g_bad_w
      $error("lbist_lfsr: W must be at least 2");
   end

   logic fb;
   assign fb     = (^(q & TAPS)) ^ ser_in;
   assign q_next = {q[W-2:0], fb};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= SEED;
      else if (seed_load) q <= SEED;
      else if (step)      q <= q_next;
   end
endmodule

// File: rtl/lbist_cut.sv
module lbist_cut
   import lbist_pkg::*;
(
   input  cut_src_e src,
   input  logic     t_a,
   input  logic     t_b,
   input  logic     t_s,
   input  logic     f_a,
   input  logic     f_b,
   input  logic     f_s,
   input  logic     fault_en,
   input  logic     fault_val,
   output logic     y
);
   logic a, b, s, mux_y;

   always_comb begin
      if (src == SRC_TEST) begin
         a = t_a; b = t_b; s = t_s;
      end else begin
         a = f_a; b = f_b; s = f_s;
      end
      mux_y = s ? b : a;
      y     = fault_en ? fault_val : mux_y;
   end
endmodule

// File: rtl/lbist_result_reg.sv
module lbist_result_reg #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   input  logic         tdi,
   output logic [W-1:0] q,
   output logic         tdo
);
   assign tdo = q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load)     q <= load_val;
      else if (shift_en) q <= {tdi, q[W-1:1]};
   end
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
   import lbist_pkg::*;
#(
   parameter int unsigned GEN_W    = LFSR_W_DEF,
   parameter int unsigned SIG_W    = LFSR_W_DEF,
   parameter logic [GEN_W-1:0] GEN_TAPS = TAPS_X4X3,
   parameter logic [SIG_W-1:0] SIG_TAPS = TAPS_X4X3,
   parameter logic [GEN_W-1:0] GEN_SEED = GEN_SEED_DEF,
   parameter int unsigned TEST_LEN = 15,
   parameter logic [SIG_W-1:0] GOLDEN   = 4'b0011
) (
   input  logic tck,
   input  logic rst_n,
   input  logic run_selftest,
   input  logic in_idle,
   input  logic shift_dr,
   input  logic tdi,
   output logic tdo,
   input  logic func_a,
   input  logic func_b,
   input  logic func_s,
   output logic func_y,
   input  logic fault_en,
   input  logic fault_val,
   output logic st_done
);
   localparam int unsigned CNT_W = $clog2(TEST_LEN + 1);
   localparam int unsigned RES_W = SIG_W + 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TEST_LEN - 1);

   if (GEN_W < 3) begin : g_bad_gen
      $error("lbist_engine: generator needs at least 3 bits for A, B, S");
   end
   if (TEST_LEN < 1) begin : g_bad_len
      $error("lbist_engine: TEST_LEN must be at least 1");
   end

   logic             run_q;
   logic             done_q;
   logic [CNT_W-1:0] cnt_q;
   logic             entry, advance, last;
   logic [GEN_W-1:0] gen_q, gen_nx;
   logic [SIG_W-1:0] sig_q, sig_nx;
   logic [RES_W-1:0] res_q;
   logic             cut_y;
   cut_src_e         src;

   assign entry   = run_selftest & ~run_q;
   assign advance = run_selftest & in_idle & ~done_q & ~entry;
   assign last    = advance & (cnt_q == LAST_CNT);
   assign src     = run_selftest ? SRC_TEST : SRC_FUNC;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         run_q <= run_selftest;
         if (entry) begin
            done_q <= 1'b0;
            cnt_q  <= '0;
         end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) done_q <= 1'b1;
         end
      end
   end

   lbist_lfsr #(.W(GEN_W), .TAPS(GEN_TAPS), .SEED(GEN_SEED)) u_gen (
      .clk(tck), .rst_n(rst_n), .seed_load(entry), .step(advance),
      .ser_in(1'b0), .q(gen_q), .q_next(gen_nx)
   );

   lbist_lfsr #(.W(SIG_W), .TAPS(SIG_TAPS), .SEED('0)) u_sig (
      .clk(tck), .rst_n(rst_n), .seed_load(entry), .step(advance),
      .ser_in(cut_y), .q(sig_q), .q_next(sig_nx)
   );

   lbist_cut u_cut (
      .src(src), .t_a(gen_q[0]), .t_b(gen_q[1]), .t_s(gen_q[2]),
      .f_a(func_a), .f_b(func_b), .f_s(func_s),
      .fault_en(fault_en), .fault_val(fault_val), .y(cut_y)
   );

   lbist_result_reg #(.W(RES_W)) u_res (
      .clk(tck), .rst_n(rst_n), .load(last),
      .load_val({sig_nx == GOLDEN, sig_nx}),
      .shift_en(shift_dr & ~last), .tdi(tdi), .q(res_q), .tdo(tdo)
   );

   assign func_y  = cut_y;
   assign st_done = done_q;
endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk #(
   parameter int unsigned GEN_W    = 4,
   parameter int unsigned SIG_W    = 4,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned TEST_LEN = 15,
   parameter logic [GEN_W-1:0] GEN_SEED = 4'b0001
) (
   input logic             tck,
   input logic             rst_n,
   input logic             run_selftest,
   input logic             run_q,
   input logic             in_idle,
   input logic             shift_dr,
   input logic             st_done,
   input logic [CNT_W-1:0] cnt_q,
   input logic [GEN_W-1:0] gen_q,
   input logic [SIG_W-1:0] sig_q,
   input logic [SIG_W:0]   res_q,
   input logic             func_y,
   input logic             fault_en,
   input logic             fault_val
);
   logic entry_c;
   assign entry_c = run_selftest & ~run_q;

   a_r9_entry_clears: assert property (@(posedge tck) disable iff (!rst_n)
      entry_c |=> (!st_done && cnt_q == '0 && gen_q == GEN_SEED && sig_q == '0));

   a_r4_hold_off_idle: assert property (@(posedge tck) disable iff (!rst_n)
      (!entry_c && !(run_selftest && in_idle)) |=>
         ($stable(gen_q) && $stable(sig_q) && $stable(cnt_q)));

   a_r5_done_at_len: assert property (@(posedge tck) disable iff (!rst_n)
      $rose(st_done) |-> ($past(cnt_q) == CNT_W'(TEST_LEN - 1)));

   a_r10_result_frozen: assert property (@(posedge tck) disable iff (!rst_n)
      (st_done && !entry_c && !shift_dr) |=> $stable(res_q));

   a_r8_shift_lsb: assert property (@(posedge tck) disable iff (!rst_n)
      (shift_dr && !in_idle) |=> (res_q[SIG_W-1:0] == $past(res_q[SIG_W:1])));

   always_comb begin
      if (rst_n && fault_en) begin
         a_r11_fault_forces: assert (func_y == fault_val);
      end
   end
endmodule

bind lbist_engine lbist_engine_chk #(
   .GEN_W(GEN_W), .SIG_W(SIG_W), .CNT_W(CNT_W),
   .TEST_LEN(TEST_LEN), .GEN_SEED(GEN_SEED)
) u_chk (
   .tck(tck), .rst_n(rst_n), .run_selftest(run_selftest), .run_q(run_q),
   .in_idle(in_idle), .shift_dr(shift_dr), .st_done(st_done),
   .cnt_q(cnt_q), .gen_q(gen_q), .sig_q(sig_q), .res_q(res_q),
   .func_y(func_y), .fault_en(fault_en), .fault_val(fault_val)
);

// File: tb/lbist_engine_bench.sv
`timescale 1ns/1ps
module lbist_engine_bench;
   localparam int          LEN  = 15;
   localparam logic [3:0]  GOLD = 4'b0011;

   logic tck = 1'b0;
   logic rst_n, run_selftest, in_idle, shift_dr, tdi, tdo;
   logic func_a, func_b, func_s, func_y, fault_en, fault_val, st_done;

   int checks = 0;
   int fails  = 0;

   always #4 tck = ~tck;

   lbist_engine u_lbist_engine (
      .tck(tck), .rst_n(rst_n), .run_selftest(run_selftest), .in_idle(in_idle),
      .shift_dr(shift_dr), .tdi(tdi), .tdo(tdo), .func_a(func_a), .func_b(func_b),
      .func_s(func_s), .func_y(func_y), .fault_en(fault_en), .fault_val(fault_val),
      .st_done(st_done)
   );

   function automatic logic [3:0] gen_step(input logic [3:0] g);
      return {g[2:0], g[3] ^ g[2]};
   endfunction
   function automatic logic [3:0] sig_step(input logic [3:0] s, input logic y);
      return {s[2:0], s[3] ^ s[2] ^ y};
   endfunction
   function automatic logic mux(input logic a, input logic b, input logic s);
      return s ? b : a;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // one self-test run; returns the expected 5-bit result
   task automatic do_run(input bit fe, input bit fv, input bit gaps,
                         input bit entry_idle, output logic [4:0] exp_res);
      logic [3:0] mg = 4'b0001;
      logic [3:0] ms = 4'b0000;
      logic       y;
      int         n = 0;
      bit         act;
      @(negedge tck);
      fault_en = fe; fault_val = fv; shift_dr = 1'b0;
      run_selftest = 1'b1; in_idle = entry_idle;   // R9 entry collides with idle
      @(negedge tck);
      chk("R9 done cleared on entry", {7'd0, st_done}, 8'd0);
      while (n < LEN) begin
         act = gaps ? ($urandom_range(0, 2) != 0) : 1'b1;
         in_idle = act;
         #1;
         y = fe ? fv : mux(mg[0], mg[1], mg[2]);
         chk(fe ? "R11 fault in test" : "R3 pattern drives mux", {7'd0, func_y}, {7'd0, y});
         @(negedge tck);
         if (act) begin
            ms = sig_step(ms, y);
            mg = gen_step(mg);
            n++;
         end
         chk("R4 R5 done timing", {7'd0, st_done}, {7'd0, n == LEN});
      end
      in_idle = 1'b1;
      repeat (3) @(negedge tck);   // R10 idle after done
      in_idle = 1'b0;
      exp_res = {ms == GOLD, ms};
   endtask

   task automatic shift_out(input logic [4:0] exp_res, input string req);
      logic [4:0] got;
      shift_dr = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tdi = 1'($urandom_range(0, 1));
         #1;
         got[i] = tdo;
         @(negedge tck);
      end
      shift_dr = 1'b0;
      chk(req, {3'd0, got}, {3'd0, exp_res});
   endtask

   initial begin
      logic [4:0] er;
      logic [4:0] pat;
      void'($urandom(32'd1234));
      rst_n = 1'b0; run_selftest = 1'b0; in_idle = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
      func_a = 1'b0; func_b = 1'b0; func_s = 1'b0; fault_en = 1'b0; fault_val = 1'b0;
      repeat (3) @(negedge tck);
      rst_n = 1'b1;
      @(negedge tck);
      // R1 reset state
      chk("R1 done after reset", {7'd0, st_done}, 8'd0);
      chk("R1 tdo after reset", {7'd0, tdo}, 8'd0);

      // R2 functional mode, random
      for (int i = 0; i < 20; i++) begin
         func_a = 1'($urandom_range(0, 1));
         func_b = 1'($urandom_range(0, 1));
         func_s = 1'($urandom_range(0, 1));
         in_idle = 1'($urandom_range(0, 1));
         #1;
         chk("R2 functional mux", {7'd0, func_y}, {7'd0, mux(func_a, func_b, func_s)});
         @(negedge tck);
      end
      in_idle = 1'b0;

      // R11 fault in functional mode
      for (int v = 0; v < 2; v++) begin
         fault_en = 1'b1; fault_val = 1'(v);
         func_s = 1'b0; func_a = ~fault_val;
         #1;
         chk("R11 fault functional", {7'd0, func_y}, {7'd0, fault_val});
         @(negedge tck);
      end
      fault_en = 1'b0;

      // R8 plain data register while instruction inactive
      pat = 5'b10110;
      shift_dr = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tdi = pat[i];
         @(negedge tck);
      end
      shift_dr = 1'b0;
      shift_out(pat, "R8 plain DR shift LSB first");

      // R5 R6 R7 fault-free run, no gaps
      do_run(1'b0, 1'b0, 1'b0, 1'b0, er);
      chk("R6 golden signature", {4'd0, er[3:0]}, {4'd0, GOLD});
      chk("R7 pass expected", {7'd0, er[4]}, 8'd1);
      shift_out(er, "R5 R10 shifted result");
      run_selftest = 1'b0;
      @(negedge tck);
      chk("R9 done held until re-entry", {7'd0, st_done}, 8'd1);

      // R4 gaps, R9 entry with idle in same cycle
      do_run(1'b0, 1'b0, 1'b1, 1'b1, er);
      shift_out(er, "R4 R9 result with gaps");
      run_selftest = 1'b0;
      @(negedge tck);

      // R9 abort part way then restart
      run_selftest = 1'b1; in_idle = 1'b1;
      repeat (6) @(negedge tck);
      run_selftest = 1'b0; in_idle = 1'b0;
      @(negedge tck);
      do_run(1'b0, 1'b0, 1'b1, 1'b0, er);
      shift_out(er, "R9 restart result");
      run_selftest = 1'b0;
      @(negedge tck);

      // R7 R11 stuck-at faults
      for (int v = 0; v < 2; v++) begin
         do_run(1'b1, 1'(v), 1'b1, 1'b0, er);
         chk("R7 pass cleared under fault", {7'd0, er[4]}, 8'd0);
         shift_out(er, "R7 faulty result");
         run_selftest = 1'b0; fault_en = 1'b0;
         @(negedge tck);
      end

      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge tck);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end
endmodule